// File: doc/BRIEF.md
# Pipe Event Interrupt Aggregator

This block gathers interrupt events from several display pipes and turns them into a single CPU interrupt line. It works in two levels. Each pipe owns a status word. The word holds sticky event bits and, beside them, an enable bit for each event. The enabled events of a pipe are ORed into one live bit of a summary register. A latched identity register records which pipes have raised an event. A per-bit mask then decides which identity bits may drive the interrupt output.

A build parameter selects how the identity register captures the summary bits. In level mode an identity bit is set in every cycle in which its summary bit is high. In edge mode it is set only when the summary bit rises. In edge mode, software that acknowledges only part of a pipe's pending events must pull the summary bit low and release it again. It does this by writing the pipe's enables to zero and then restoring them, so that the remaining events produce a fresh rising edge. If software skips this step, a late event can leave the identity bit at zero while the summary bit reads one. The block keeps that behaviour on purpose.

Software reaches all registers through a plain write port and a combinational read port that share one address space. Each pipe sends its events as one-cycle pulses.

Top module: `pipe_irq_aggregator`

## Requirements
- R1: After reset every readable register (pipe words, summary, identity, mask) reads zero and the interrupt output is low.
- R2: An event pulse on a pipe input sets the matching status bit on the next clock edge. The bit then stays set until software clears it. If a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R3: A pipe word places the status bits in its lower EVT_W bits and the enable bits in its upper EVT_W bits. A write to the word replaces all enables with the written upper half and clears each status bit whose lower-half bit is written as one.
- R4: Summary bit p is high exactly when pipe p has at least one status bit set whose enable is also set. A write that sets all enables of a pipe to zero makes its summary bit read low in the next cycle, even with status bits still set.
- R5: In edge mode an identity bit is set one cycle after its summary bit rises. A summary bit that stays high does not set it again after a clear, so the identity bit can read zero while the summary bit reads one.
- R6: In edge mode, writing a pipe's enables to zero and then restoring them while a status bit is still set makes the summary bit rise again. The identity bit is set one cycle after the restore takes effect.
- R7: In level mode an identity bit is set in every cycle in which its summary bit is high, so a clear written while the summary bit is high leaves the identity bit set.
- R8: Writing ones to the identity register clears those bits. If a set and a clear meet on the same bit in the same cycle, the set wins.
- R9: A mask bit of one blocks its identity bit. The interrupt output is high exactly when an identity bit is set and its mask bit is zero.
- R10: Pipe p sits at address p. The summary register sits at NUM_PIPES, the identity register at NUM_PIPES+1 and the mask at NUM_PIPES+2. All other addresses read zero and ignore writes, and writes to the summary register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_PIPES*EVT_W | One-cycle event pulses, pipe p in bits [p*EVT_W +: EVT_W] |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 2*EVT_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 2*EVT_W | Combinational read data |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The bench drives the edge-mode and the level-mode build with the same stimulus. For each pipe it sweeps all 256 pairs of enable pattern and event pattern on a narrow configuration. This separates a correct masked OR in the summary bit from one that ignores the enables or the status bits. It also shows the two capture modes diverging. A directed sequence replays the partial-acknowledge race, which reaches the stuck state only in edge mode. It then runs the enable toggle that repairs it and measures the one-cycle latency of the re-arm. Further directed cases cover simultaneous set and clear on both the status and the identity bits, every mask pattern, and writes to the summary register and to unmapped addresses.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;

  // Kind of register an address selects
  typedef enum logic [2:0] {
    RK_PIPE = 3'd0,
    RK_ISR  = 3'd1,
    RK_IIR  = 3'd2,
    RK_IMR  = 3'd3,
    RK_NONE = 3'd4
  } reg_kind_e;

  // Address map: pipes first, then summary, identity, mask
  function automatic reg_kind_e classify(input int unsigned addr, input int unsigned npipes);
    if (addr < npipes)          return RK_PIPE;
    else if (addr == npipes)    return RK_ISR;
    else if (addr == npipes + 1) return RK_IIR;
    else if (addr == npipes + 2) return RK_IMR;
    else                        return RK_NONE;
  endfunction

endpackage

// File: rtl/irq_pipe_status.sv
`timescale 1ns/1ps
module irq_pipe_status #(
  parameter int EVT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit_i,
  input  logic [2*EVT_W-1:0] wr_data_i,
  input  logic [EVT_W-1:0]   evt_i,
  output logic [EVT_W-1:0]   stat_o,
  output logic [EVT_W-1:0]   en_o,
  output logic               isr_o
);

  localparam int DW = 2 * EVT_W;

  // Sticky status: clear by write-one, new event wins
  function automatic logic [EVT_W-1:0] next_status(input logic [EVT_W-1:0] cur,
                                                   input logic [EVT_W-1:0] w1c,
                                                   input logic [EVT_W-1:0] evt);
    return (cur & ~w1c) | evt;
  endfunction

  // Reduction of enabled events to one live bit
  function automatic logic armed(input logic [EVT_W-1:0] stat, input logic [EVT_W-1:0] en);
    return |(stat & en);
  endfunction

  logic [EVT_W-1:0] stat_q;
  logic [EVT_W-1:0] en_q;
  logic [EVT_W-1:0] w1c_w;
  logic [EVT_W-1:0] en_wr_w;

  assign w1c_w   = wr_hit_i ? wr_data_i[EVT_W-1:0] : '0;
  assign en_wr_w = wr_data_i[DW-1:EVT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= next_status(stat_q, w1c_w, evt_i);
      if (wr_hit_i) en_q <= en_wr_w;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign isr_o  = armed(stat_q, en_q);

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  // R3
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_i |=> (en_o == $past(wr_data_i[DW-1:EVT_W])));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_i |=> ((stat_o & $past(wr_data_i[EVT_W-1:0] & ~evt_i)) == '0));

  // R4
  isr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_i && (wr_data_i[DW-1:EVT_W] == '0)) |=> !isr_o);

endmodule

// File: rtl/irq_identity.sv
`timescale 1ns/1ps
module irq_identity #(
  parameter int NUM_PIPES = 2,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PIPES-1:0] isr_i,
  input  logic [NUM_PIPES-1:0] clr_i,
  output logic [NUM_PIPES-1:0] iir_o,
  output logic [NUM_PIPES-1:0] set_o
);

  // Latch update: set takes priority over write-one clear
  function automatic logic [NUM_PIPES-1:0] next_iir(input logic [NUM_PIPES-1:0] cur,
                                                    input logic [NUM_PIPES-1:0] clr,
                                                    input logic [NUM_PIPES-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic [NUM_PIPES-1:0] iir_q;
  logic [NUM_PIPES-1:0] set_w;

  generate
    if (EDGE_MODE) begin : g_edge
      logic [NUM_PIPES-1:0] hist_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= isr_i;
      end

      assign set_w = isr_i & ~hist_q;

      // R5
      held_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(isr_i & hist_q & clr_i)) |=> ((iir_q & $past(isr_i & hist_q & clr_i)) == '0));

      // R6
      rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(isr_i & ~hist_q)) |=> ((iir_q & $past(isr_i & ~hist_q)) == $past(isr_i & ~hist_q)));
    end else begin : g_level
      assign set_w = isr_i;

      // R7
      level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|isr_i) |=> ((iir_q & $past(isr_i)) == $past(isr_i)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iir_q <= '0;
    else        iir_q <= next_iir(iir_q, clr_i, set_w);
  end

  assign iir_o = iir_q;
  assign set_o = set_w;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_o & clr_i)) |=> ((iir_o & $past(set_o & clr_i)) == $past(set_o & clr_i)));

  // R8
  w1c_iir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_o)) |=> ((iir_o & $past(clr_i & ~set_o)) == '0));

endmodule

// File: rtl/irq_mask_out.sv
`timescale 1ns/1ps
module irq_mask_out #(
  parameter int NUM_PIPES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_hit_i,
  input  logic [NUM_PIPES-1:0] wr_data_i,
  input  logic [NUM_PIPES-1:0] iir_i,
  output logic [NUM_PIPES-1:0] imr_o,
  output logic                 irq_o
);

  // One in the mask blocks the matching identity bit
  function automatic logic gate_irq(input logic [NUM_PIPES-1:0] iir,
                                    input logic [NUM_PIPES-1:0] imr);
    return |(iir & ~imr);
  endfunction

  logic [NUM_PIPES-1:0] imr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        imr_q <= '0;
    else if (wr_hit_i) imr_q <= wr_data_i;
  end

  assign imr_o = imr_q;
  assign irq_o = gate_irq(iir_i, imr_q);

  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_i |=> (imr_o == $past(wr_data_i)));

  // R9
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&imr_o) |-> !irq_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_i == '0) |-> !irq_o);

endmodule

// File: rtl/pipe_irq_aggregator.sv
`timescale 1ns/1ps
module pipe_irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_PIPES = 2,
  parameter int EVT_W     = 8,
  parameter int ADDR_W    = 3,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PIPES*EVT_W-1:0] evt_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [2*EVT_W-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [2*EVT_W-1:0]         rd_data_o,
  output logic                       irq_o
);

  localparam int DW   = 2 * EVT_W;
  localparam int ZPAD = DW - NUM_PIPES;

  reg_kind_e wr_kind_w;
  reg_kind_e rd_kind_w;

  logic [EVT_W-1:0]     stat_arr [NUM_PIPES];
  logic [EVT_W-1:0]     en_arr   [NUM_PIPES];
  logic [NUM_PIPES-1:0] pipe_hit_w;
  logic [NUM_PIPES-1:0] isr_w;
  logic [NUM_PIPES-1:0] iir_w;
  logic [NUM_PIPES-1:0] iir_clr_w;
  logic [NUM_PIPES-1:0] iir_set_w;
  logic [NUM_PIPES-1:0] imr_w;
  logic                 imr_hit_w;

  assign wr_kind_w = classify(32'(wr_addr_i), NUM_PIPES);
  assign rd_kind_w = classify(32'(rd_addr_i), NUM_PIPES);

  assign iir_clr_w = (wr_en_i && wr_kind_w == RK_IIR) ? wr_data_i[NUM_PIPES-1:0] : '0;
  assign imr_hit_w = wr_en_i && (wr_kind_w == RK_IMR);

  generate
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      assign pipe_hit_w[p] = wr_en_i && (wr_addr_i == ADDR_W'(p));

      irq_pipe_status #(
        .EVT_W (EVT_W)
      ) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit_i  (pipe_hit_w[p]),
        .wr_data_i (wr_data_i),
        .evt_i     (evt_i[p*EVT_W +: EVT_W]),
        .stat_o    (stat_arr[p]),
        .en_o      (en_arr[p]),
        .isr_o     (isr_w[p])
      );
    end
  endgenerate

  irq_identity #(
    .NUM_PIPES (NUM_PIPES),
    .EDGE_MODE (EDGE_MODE)
  ) u_iir (
    .clk   (clk),
    .rst_n (rst_n),
    .isr_i (isr_w),
    .clr_i (iir_clr_w),
    .iir_o (iir_w),
    .set_o (iir_set_w)
  );

  irq_mask_out #(
    .NUM_PIPES (NUM_PIPES)
  ) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit_i  (imr_hit_w),
    .wr_data_i (wr_data_i[NUM_PIPES-1:0]),
    .iir_i     (iir_w),
    .imr_o     (imr_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_kind_w)
      RK_PIPE: begin
        for (int p = 0; p < NUM_PIPES; p++) begin
          if (rd_addr_i == ADDR_W'(p)) rd_data_o = {en_arr[p], stat_arr[p]};
        end
      end
      RK_ISR:  rd_data_o = {{ZPAD{1'b0}}, isr_w};
      RK_IIR:  rd_data_o = {{ZPAD{1'b0}}, iir_w};
      RK_IMR:  rd_data_o = {{ZPAD{1'b0}}, imr_w};
      default: rd_data_o = '0;
    endcase
  end

  // R8
  iir_set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|iir_set_w) |-> ((iir_set_w & ~isr_w) == '0));

endmodule

// File: tb/sim_pipe_irq_aggregator.sv
`timescale 1ns/100ps
module sim_pipe_irq_aggregator;

  localparam int CLK_PERIOD = 10;
  localparam int NP  = 2;
  localparam int W   = 4;
  localparam int DW  = 2 * W;
  localparam int AW  = 3;
  localparam int NRD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [NP*W-1:0] evt = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic [DW-1:0]   rd_e, rd_l;
  logic            irq_e, irq_l;

  pipe_irq_aggregator #(.NUM_PIPES(NP), .EVT_W(W), .ADDR_W(AW), .EDGE_MODE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_e), .irq_o(irq_e));

  pipe_irq_aggregator #(.NUM_PIPES(NP), .EVT_W(W), .ADDR_W(AW), .EDGE_MODE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_l), .irq_o(irq_l));

  int n_chk = 0;
  int n_fail = 0;

  // Expected state derived from the requirements
  logic [W-1:0]  m_stat [NP];
  logic [W-1:0]  m_en   [NP];
  logic [NP-1:0] m_iir_e = '0;
  logic [NP-1:0] m_iir_l = '0;
  logic [NP-1:0] m_hist  = '0;
  logic [NP-1:0] m_imr   = '0;

  function automatic logic [NP-1:0] m_isr();
    logic [NP-1:0] v = '0;
    for (int p = 0; p < NP; p++) v[p] = (m_stat[p] & m_en[p]) != '0;
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_rd(input int a, input bit edge_mode);
    if (a < NP)      return {m_en[a], m_stat[a]};
    if (a == NP)     return DW'(m_isr());
    if (a == NP + 1) return edge_mode ? DW'(m_iir_e) : DW'(m_iir_l);
    if (a == NP + 2) return DW'(m_imr);
    return '0;
  endfunction

  function automatic string req_of(input int a, input bit edge_mode);
    if (a < NP)      return "R3";
    if (a == NP)     return "R4";
    if (a == NP + 1) return edge_mode ? "R5" : "R7";
    if (a == NP + 2) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // One clock cycle of stimulus; model advances at the edge
  task automatic step(input logic we, input int wa, input logic [DW-1:0] wd,
                      input logic [NP*W-1:0] ev);
    logic [NP-1:0] isr_now;
    logic [NP-1:0] clr;
    wr_en = we; wr_addr = AW'(wa); wr_data = wd; evt = ev;
    @(posedge clk);
    isr_now = m_isr();
    clr = (we && wa == NP + 1) ? wd[NP-1:0] : '0;
    m_iir_e = (m_iir_e & ~clr) | (isr_now & ~m_hist);
    m_iir_l = (m_iir_l & ~clr) | isr_now;
    m_hist  = isr_now;
    for (int p = 0; p < NP; p++) begin
      if (we && wa == p) begin
        m_en[p]   = wd[DW-1:W];
        m_stat[p] = (m_stat[p] & ~wd[W-1:0]) | ev[p*W +: W];
      end else begin
        m_stat[p] = m_stat[p] | ev[p*W +: W];
      end
    end
    if (we && wa == NP + 2) m_imr = wd[NP-1:0];
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] ve, output logic [DW-1:0] vl);
    rd_addr = AW'(a);
    #0.5;
    ve = rd_e;
    vl = rd_l;
  endtask

  task automatic check_all();
    for (int a = 0; a < NRD; a++) begin
      rd_addr = AW'(a);
      #0.5;
      check(req_of(a, 1'b1), "edge read", rd_e, exp_rd(a, 1'b1));
      check(req_of(a, 1'b0), "level read", rd_l, exp_rd(a, 1'b0));
    end
    check("R9", "edge irq", DW'(irq_e), DW'(|(m_iir_e & ~m_imr)));
    check("R9", "level irq", DW'(irq_l), DW'(|(m_iir_l & ~m_imr)));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] ve, vl;
    for (int p = 0; p < NP; p++) begin m_stat[p] = '0; m_en[p] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    for (int a = 0; a < NRD; a++) begin
      rd(a, ve, vl);
      check("R1", "edge reset read", ve, '0);
      check("R1", "level reset read", vl, '0);
    end
    check("R1", "irq after reset", DW'({irq_e, irq_l}), '0);

    // R2: sticky status, event wins over clear
    step(1'b1, 0, 8'hFF, '0);
    step(1'b0, 0, '0, 8'h01);
    rd(0, ve, vl);
    check("R2", "event sets bit", DW'(ve[W-1:0]), 8'h01);
    step(1'b0, 0, '0, '0);
    step(1'b0, 0, '0, '0);
    rd(0, ve, vl);
    check("R2", "bit stays set", DW'(ve[W-1:0]), 8'h01);
    step(1'b1, 0, 8'hF1, 8'h01);
    rd(0, ve, vl);
    check("R2", "event beats clear", DW'(ve[W-1:0]), 8'h01);
    step(1'b1, 0, 8'hF1, '0);
    rd(0, ve, vl);
    check("R3", "write one clears", DW'(ve[W-1:0]), 8'h00);
    check_all();

    // R3/R4 sweep: every enable pattern against every event pattern
    for (int p = 0; p < NP; p++) begin
      for (int en = 0; en < 16; en++) begin
        for (int st = 0; st < 16; st++) begin
          step(1'b1, p, DW'({4'(en), 4'hF}), '0);
          step(1'b1, NP + 1, 8'h03, '0);
          step(1'b0, 0, '0, (NP*W)'(st) << (p * W));
          step(1'b0, 0, '0, '0);
          check_all();
        end
      end
    end

    // clean state
    step(1'b1, 0, 8'h0F, '0);
    step(1'b1, 1, 8'h0F, '0);
    step(1'b0, 0, '0, '0);
    step(1'b1, NP + 1, 8'h03, '0);
    step(1'b1, NP + 2, 8'h00, '0);
    check_all();

    // R5: partial acknowledge race
    step(1'b1, 0, 8'hFF, '0);
    step(1'b0, 0, '0, 8'h01);
    step(1'b0, 0, '0, '0);
    rd(NP + 1, ve, vl);
    check("R5", "edge iir after rise", ve, 8'h01);
    step(1'b0, 0, '0, 8'h02);
    step(1'b1, 0, 8'hF1, '0);
    step(1'b1, NP + 1, 8'h01, '0);
    rd(NP, ve, vl);
    check("R5", "summary still high", ve, 8'h01);
    rd(NP + 1, ve, vl);
    check("R5", "edge iir stuck low", ve, 8'h00);
    check("R7", "level iir re-set", vl, 8'h01);
    step(1'b0, 0, '0, '0);
    rd(NP + 1, ve, vl);
    check("R5", "edge iir stays low", ve, 8'h00);
    check("R5", "edge irq low", DW'(irq_e), 8'h00);

    // R6: enable toggle re-arms the edge
    step(1'b1, 0, 8'h00, '0);
    rd(NP, ve, vl);
    check("R4", "zero enables drop summary", ve, 8'h00);
    step(1'b1, 0, 8'hF0, '0);
    rd(NP, ve, vl);
    check("R6", "summary rises again", ve, 8'h01);
    rd(NP + 1, ve, vl);
    check("R6", "edge iir one cycle later", ve, 8'h00);
    step(1'b0, 0, '0, '0);
    rd(NP + 1, ve, vl);
    check("R6", "edge iir re-armed", ve, 8'h01);
    check("R6", "edge irq raised", DW'(irq_e), 8'h01);
    check_all();

    // R8: set wins over same-cycle clear, then plain clear
    step(1'b1, NP + 1, 8'h03, '0);
    step(1'b1, 1, 8'hFF, '0);
    step(1'b0, 0, '0, 8'h10);
    step(1'b1, NP + 1, 8'h02, '0);
    rd(NP + 1, ve, vl);
    check("R8", "set beats clear", ve, 8'h02);
    step(1'b1, NP + 1, 8'h02, '0);
    rd(NP + 1, ve, vl);
    check("R8", "write one clears iir", ve, 8'h00);
    check_all();

    // R9: every mask pattern
    for (int m = 0; m < 4; m++) begin
      step(1'b1, NP + 2, DW'(m), '0);
      check("R9", "level irq vs mask", DW'(irq_l), DW'((2'b11 & ~2'(m)) != 0));
      check("R9", "edge irq vs mask", DW'(irq_e), 8'h00);
      check_all();
    end

    // R10: writes to summary and unmapped addresses ignored
    step(1'b1, NP, 8'hFF, '0);
    step(1'b1, 6, 8'hFF, '0);
    step(1'b1, 7, 8'hFF, '0);
    rd(NP, ve, vl);
    check("R10", "summary write ignored", ve, 8'h03);
    rd(6, ve, vl);
    check("R10", "unmapped reads zero", ve, 8'h00);
    step(1'b0, 0, '0, '0);
    check_all();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule